// File: doc/BRIEF.md
# Multiplexed Segment LCD Controller with Serial Load

The block drives a segment LCD panel with three common lines and sixty-eight segment lines at 1/3 duty and 1/3 bias. A host loads the picture over a three-wire serial link made of a chip-enable line, a shift clock and a data line. Each frame begins with an 8-bit device address. A frame reaches the display latch only if that address matches the block's own address and the frame has exactly the expected length. A free-running scan, clocked by the oscillator, steps through the three commons. Every output pin is reported as a 2-bit drive-level code. An analog stage outside the block turns each code into a bias voltage.

Any of the four lowest segment pins can be turned into a static general-purpose output by a mode bit in the frame. An active-low inhibit input blanks the panel: it drives every code to ground and returns the four dual-purpose pins to segment function. Serial loading keeps working while the panel is inhibited.

The receiver is a state machine with five states:
- RX_IDLE goes to RX_ADDR on a rising chip enable.
- RX_ADDR goes to RX_DATA after the eighth address bit if the address matches, and to RX_DROP if it does not.
- RX_DATA goes to RX_DROP when a bit arrives past the payload length.
- RX_DATA goes to RX_COMMIT on a falling chip enable with a full payload. It goes to RX_IDLE on a falling chip enable with a short payload.
- RX_ADDR and RX_DROP go to RX_IDLE on a falling chip enable.
- RX_COMMIT writes the latch and goes to RX_IDLE in the next cycle.

The scan polarity is a second state machine with two states. SCAN_POS goes to SCAN_NEG at the end of each half-phase. SCAN_NEG goes back to SCAN_POS at the end of each half-phase and advances the common index at the same time.

Top module: `seglcd_ctrl`

## Requirements
- R1: Reset clears the display latch, the port-mode bits and the port-value bits. The scan restarts at common 0 in positive polarity, so right after reset every segment reads as off and `port_fn` is 0.
- R2: A frame lasts 384 clock cycles. Count n is the number of clock edges since reset, and p = n mod 384. Common c = p/128 is selected while p is in [128c, 128c+128). The first 64 cycles of each phase have positive polarity and the last 64 have negative polarity.
- R3: Drive codes are 0 = ground, 1 = one third, 2 = two thirds, 3 = full. A selected common reads 3 in positive polarity and 0 in negative polarity. An unselected common reads 1 in positive polarity and 2 in negative polarity.
- R4: A segment whose bit is set for the currently selected common reads 0 in positive polarity and 3 in negative polarity. A segment whose bit is clear reads 2 in positive polarity and 1 in negative polarity.
- R5: Serial bits are sampled on rising shift-clock edges while chip enable is high, least significant bit first. The first 8 bits are the address. The next 212 bits form the payload:
  - payload bit s*3+c lights segment s on common c;
  - payload bits 204..207 are the port-mode bits of pins 0..3;
  - payload bits 208..211 are the port-value bits of pins 0..3.
- R6: The payload is copied to the latch on the falling edge of chip enable only when the address equals `DEV_ADDR` (default 8'h5A). A frame with another address changes nothing.
- R7: A frame whose payload is shorter or longer than 212 bits is discarded.
- R8: A pin k < 4 whose mode bit is set acts as a port. Its `port_fn[k]` reads 1, and its code is 3 if its value bit is 1 and 0 otherwise, independent of the scan.
- R9: While `inh_n` is low, every segment and common code is 0 and `port_fn` is 0, whatever the latch holds.
- R10: Frames sent while `inh_n` is low are still received and latched, and they appear on the outputs once `inh_n` returns high.
- R11: Shift-clock edges while chip enable is low have no effect on the display.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; drives the scan and samples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| inh_n | input | 1 | Active-low display inhibit |
| ser_ce | input | 1 | Serial chip enable, high during a frame |
| ser_clk | input | 1 | Serial shift clock |
| ser_di | input | 1 | Serial data, least significant bit first |
| seg_lvl | output | 136 | Two-bit drive code per segment; segment s occupies bits [2s+1:2s] |
| com_lvl | output | 6 | Two-bit drive code per common; common c occupies bits [2c+1:2c] |
| port_fn | output | 4 | Effective port function of the four dual-purpose pins |

## Verification
The bench checks every output code in every cycle over whole frames against a model of phase and polarity built from the cycle count. A scan with an off-by-one half-period or a swapped polarity would therefore fail within one phase.

Frames are sent with a wrong address, with one bit too few and with one bit too many. A design that skipped the address compare or the length check would show the wrong pattern in the sweep that follows.

Port pins are tested with value 0 and value 1 while neighbouring pins stay in segment mode, which exposes swapped mode and value fields. Inhibit is raised around a frame load, so a design that stalled the receiver during blanking would show the old picture once `inh_n` is released.

// File: rtl/seglcd_pkg.sv
package seglcd_pkg;

    typedef enum logic [1:0] {
        LVL_GND        = 2'd0,
        LVL_THIRD      = 2'd1,
        LVL_TWO_THIRDS = 2'd2,
        LVL_FULL       = 2'd3
    } drive_lvl_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ADDR,
        RX_DATA,
        RX_DROP,
        RX_COMMIT
    } rx_state_t;

    typedef enum logic {
        SCAN_POS,
        SCAN_NEG
    } scan_pol_t;

    // Common electrode level, 1/3 bias
    function automatic drive_lvl_t com_level(input logic sel, input scan_pol_t pol);
        if (pol == SCAN_POS) return sel ? LVL_FULL : LVL_THIRD;
        else                 return sel ? LVL_GND  : LVL_TWO_THIRDS;
    endfunction

    // Segment electrode level, 1/3 bias
    function automatic drive_lvl_t seg_level(input logic on, input scan_pol_t pol);
        if (pol == SCAN_POS) return on ? LVL_GND  : LVL_TWO_THIRDS;
        else                 return on ? LVL_FULL : LVL_THIRD;
    endfunction

endpackage

// File: rtl/seglcd_sync.sv
module seglcd_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/seglcd_serial_rx.sv
module seglcd_serial_rx
    import seglcd_pkg::*;
#(
    parameter int               ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h5A,
    parameter int               PAY_W    = 212
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             cl,
    input  logic             di,
    output logic             commit,
    output logic [PAY_W-1:0] payload
);

    localparam int CNT_W = $clog2(PAY_W + 1);

    rx_state_t          state_q, state_d;
    logic               ce_q, cl_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [PAY_W-1:0]   data_q;
    logic               ce_rise, ce_fall, cl_rise;
    logic [ADDR_W-1:0]  addr_next;
    logic               addr_last, pay_full;

    assign ce_rise   = ce & ~ce_q;
    assign ce_fall   = ~ce & ce_q;
    assign cl_rise   = cl & ~cl_q & ce;
    assign addr_next = {di, addr_q[ADDR_W-1:1]};
    assign addr_last = (cnt_q == CNT_W'(ADDR_W - 1));
    assign pay_full  = (cnt_q == CNT_W'(PAY_W));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: begin
                if (ce_rise) state_d = RX_ADDR;
            end
            RX_ADDR: begin
                if (ce_fall)
                    state_d = RX_IDLE;
                else if (cl_rise && addr_last)
                    state_d = (addr_next == DEV_ADDR) ? RX_DATA : RX_DROP;
            end
            RX_DATA: begin
                if (ce_fall)
                    state_d = pay_full ? RX_COMMIT : RX_IDLE;
                else if (cl_rise && pay_full)
                    state_d = RX_DROP;
            end
            RX_DROP: begin
                if (ce_fall) state_d = RX_IDLE;
            end
            RX_COMMIT: begin
                state_d = RX_IDLE;
            end
            default: state_d = RX_IDLE;
        endcase
    end

    // Datapath: edge history, bit counter, shift registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q   <= 1'b0;
            cl_q   <= 1'b0;
            cnt_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            ce_q <= ce;
            cl_q <= cl;
            if (ce_rise) begin
                cnt_q <= '0;
            end else if (cl_rise) begin
                if (state_q == RX_ADDR) begin
                    addr_q <= addr_next;
                    cnt_q  <= addr_last ? '0 : cnt_q + 1'b1;
                end else if (state_q == RX_DATA) begin
                    data_q <= {di, data_q[PAY_W-1:1]};
                    if (!pay_full) cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign commit  = (state_q == RX_COMMIT);
    assign payload = data_q;

endmodule

// File: rtl/seglcd_scan.sv
module seglcd_scan
    import seglcd_pkg::*;
#(
    parameter int NUM_COM   = 3,
    parameter int PHASE_CYC = 128,
    parameter int COM_W     = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [COM_W-1:0] com_idx,
    output scan_pol_t        pol
);

    localparam int HALF   = PHASE_CYC / 2;
    localparam int HALF_W = (HALF > 1) ? $clog2(HALF) : 1;

    scan_pol_t        pol_q, pol_d;
    logic [COM_W-1:0] com_q, com_d;
    logic [HALF_W-1:0] cyc_q;
    logic             half_end;

    assign half_end = (cyc_q == HALF_W'(HALF - 1));

    // Polarity state register and position counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= SCAN_POS;
            com_q <= '0;
            cyc_q <= '0;
        end else begin
            pol_q <= pol_d;
            com_q <= com_d;
            cyc_q <= half_end ? '0 : cyc_q + 1'b1;
        end
    end

    // Transitions
    always_comb begin
        pol_d = pol_q;
        com_d = com_q;
        unique case (pol_q)
            SCAN_POS: begin
                if (half_end) pol_d = SCAN_NEG;
            end
            SCAN_NEG: begin
                if (half_end) begin
                    pol_d = SCAN_POS;
                    com_d = (com_q == COM_W'(NUM_COM - 1)) ? '0 : com_q + 1'b1;
                end
            end
            default: pol_d = SCAN_POS;
        endcase
    end

    assign com_idx = com_q;
    assign pol     = pol_q;

endmodule

// File: rtl/seglcd_drive.sv
module seglcd_drive
    import seglcd_pkg::*;
#(
    parameter int NUM_SEG  = 68,
    parameter int NUM_COM  = 3,
    parameter int NUM_PORT = 4,
    parameter int COM_W    = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
    input  logic [NUM_SEG*NUM_COM-1:0] disp,
    input  logic [NUM_PORT-1:0]        port_mode,
    input  logic [NUM_PORT-1:0]        port_val,
    input  logic [COM_W-1:0]           com_idx,
    input  scan_pol_t                  pol,
    input  logic                       inh_n,
    output logic [2*NUM_SEG-1:0]       seg_lvl,
    output logic [2*NUM_COM-1:0]       com_lvl,
    output logic [NUM_PORT-1:0]        port_fn
);

    logic [NUM_COM-1:0] com_sel;

    genvar c, s;
    generate
        for (c = 0; c < NUM_COM; c++) begin : g_com
            assign com_sel[c]         = (com_idx == COM_W'(c));
            assign com_lvl[2*c +: 2]  = inh_n ? com_level(com_sel[c], pol) : LVL_GND;
        end

        for (s = 0; s < NUM_SEG; s++) begin : g_seg
            logic [NUM_COM-1:0] slice;
            logic               lit;
            assign slice = disp[s*NUM_COM +: NUM_COM];
            assign lit   = |(slice & com_sel);
            if (s < NUM_PORT) begin : g_dual
                logic as_port;
                assign as_port          = inh_n & port_mode[s];
                assign port_fn[s]       = as_port;
                assign seg_lvl[2*s +: 2] = !inh_n  ? LVL_GND :
                                           as_port ? (port_val[s] ? LVL_FULL : LVL_GND) :
                                                     seg_level(lit, pol);
            end else begin : g_plain
                assign seg_lvl[2*s +: 2] = inh_n ? seg_level(lit, pol) : LVL_GND;
            end
        end
    endgenerate

endmodule

// File: rtl/seglcd_ctrl.sv
module seglcd_ctrl
    import seglcd_pkg::*;
#(
    parameter int               NUM_SEG     = 68,
    parameter int               NUM_COM     = 3,
    parameter int               NUM_PORT    = 4,
    parameter int               PHASE_CYC   = 128,
    parameter int               ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] DEV_ADDR    = 8'h5A,
    parameter int               SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   inh_n,
    input  logic                   ser_ce,
    input  logic                   ser_clk,
    input  logic                   ser_di,
    output logic [2*NUM_SEG-1:0]   seg_lvl,
    output logic [2*NUM_COM-1:0]   com_lvl,
    output logic [NUM_PORT-1:0]    port_fn
);

    localparam int DISP_W = NUM_SEG * NUM_COM;
    localparam int PAY_W  = DISP_W + 2 * NUM_PORT;
    localparam int COM_W  = (NUM_COM > 1) ? $clog2(NUM_COM) : 1;

    logic [2:0]          ser_sync;
    logic                commit;
    logic [PAY_W-1:0]    payload;
    logic [DISP_W-1:0]   disp_q;
    logic [NUM_PORT-1:0] mode_q, val_q;
    logic [COM_W-1:0]    com_idx;
    scan_pol_t           pol;

    seglcd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_di, ser_clk, ser_ce}),
        .q     (ser_sync)
    );

    seglcd_serial_rx #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR), .PAY_W(PAY_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce      (ser_sync[0]),
        .cl      (ser_sync[1]),
        .di      (ser_sync[2]),
        .commit  (commit),
        .payload (payload)
    );

    // Display and port latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_q <= '0;
            mode_q <= '0;
            val_q  <= '0;
        end else if (commit) begin
            disp_q <= payload[DISP_W-1:0];
            mode_q <= payload[DISP_W +: NUM_PORT];
            val_q  <= payload[DISP_W+NUM_PORT +: NUM_PORT];
        end
    end

    seglcd_scan #(.NUM_COM(NUM_COM), .PHASE_CYC(PHASE_CYC), .COM_W(COM_W)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .com_idx (com_idx),
        .pol     (pol)
    );

    seglcd_drive #(.NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM), .NUM_PORT(NUM_PORT), .COM_W(COM_W)) u_drive (
        .disp      (disp_q),
        .port_mode (mode_q),
        .port_val  (val_q),
        .com_idx   (com_idx),
        .pol       (pol),
        .inh_n     (inh_n),
        .seg_lvl   (seg_lvl),
        .com_lvl   (com_lvl),
        .port_fn   (port_fn)
    );

endmodule

// File: rtl/seglcd_ctrl_chk.sv
module seglcd_ctrl_chk #(
    parameter int NUM_SEG  = 68,
    parameter int NUM_COM  = 3,
    parameter int NUM_PORT = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 inh_n,
    input logic [2*NUM_SEG-1:0] seg_lvl,
    input logic [2*NUM_COM-1:0] com_lvl,
    input logic [NUM_PORT-1:0]  port_fn
);

    int sel_cnt;

    always_comb begin
        sel_cnt = 0;
        for (int c = 0; c < NUM_COM; c++) begin
            if (com_lvl[2*c +: 2] == 2'd0 || com_lvl[2*c +: 2] == 2'd3) sel_cnt++;
        end
    end

    AST_RESET_SEG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> port_fn == '0) else $error("port function set after reset"); // R1

    AST_COM0_POL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (inh_n && $past(inh_n) && $past(com_lvl[1:0]) == 2'd3 && com_lvl[1:0] != 2'd3)
        |-> com_lvl[1:0] == 2'd0) else $error("common 0 left full level other than to ground"); // R2

    AST_ONE_COM_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        inh_n |-> sel_cnt == 1) else $error("not exactly one selected common"); // R3

    AST_INHIBIT_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !inh_n |-> (seg_lvl == '0 && com_lvl == '0 && port_fn == '0)) else $error("inhibit not blanking"); // R9

    genvar k;
    generate
        for (k = 0; k < NUM_PORT; k++) begin : g_port_chk
            AST_PORT_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
                port_fn[k] |-> (seg_lvl[2*k +: 2] == 2'd0 || seg_lvl[2*k +: 2] == 2'd3))
                else $error("port pin at mid level"); // R8
        end
    endgenerate

endmodule

bind seglcd_ctrl seglcd_ctrl_chk #(
    .NUM_SEG  (NUM_SEG),
    .NUM_COM  (NUM_COM),
    .NUM_PORT (NUM_PORT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .inh_n   (inh_n),
    .seg_lvl (seg_lvl),
    .com_lvl (com_lvl),
    .port_fn (port_fn)
);

// File: tb/seglcd_ctrl_tb.sv
module seglcd_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 68;
    localparam int NC = 3;
    localparam int NP = 4;
    localparam int PH = 128;
    localparam int DW = NS * NC;
    localparam int PW = DW + 2 * NP;
    localparam int FRAME = NC * PH;
    localparam logic [7:0] ADDR = 8'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic inh_n = 1'b1;
    logic ser_ce = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_di = 1'b0;
    logic [2*NS-1:0] seg_lvl;
    logic [2*NC-1:0] com_lvl;
    logic [NP-1:0]   port_fn;

    int n_chk = 0;
    int n_err = 0;
    int tick = 0;
    logic [DW-1:0] m_disp = '0;
    logic [NP-1:0] m_mode = '0;
    logic [NP-1:0] m_val  = '0;

    seglcd_ctrl u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .inh_n   (inh_n),
        .ser_ce  (ser_ce),
        .ser_clk (ser_clk),
        .ser_di  (ser_di),
        .seg_lvl (seg_lvl),
        .com_lvl (com_lvl),
        .port_fn (port_fn)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) tick <= 0;
        else        tick <= tick + 1;
    end

    // Expected outputs from cycle count and model latch (R2 R3 R4 R8 R9)
    task automatic check_outputs(input string tag);
        int p = tick % FRAME;
        int c = p / PH;
        bit neg = (p % PH) >= (PH / 2);
        logic [2*NS-1:0] es;
        logic [2*NC-1:0] ec;
        logic [NP-1:0]   ef;
        for (int k = 0; k < NC; k++) begin
            if (!inh_n)      ec[2*k +: 2] = 2'd0;
            else if (k == c) ec[2*k +: 2] = neg ? 2'd0 : 2'd3;
            else             ec[2*k +: 2] = neg ? 2'd2 : 2'd1;
        end
        for (int s = 0; s < NS; s++) begin
            logic [1:0] lv;
            if (m_disp[s*NC + c]) lv = neg ? 2'd3 : 2'd0;
            else                  lv = neg ? 2'd1 : 2'd2;
            if (s < NP && m_mode[s]) lv = m_val[s] ? 2'd3 : 2'd0;
            if (!inh_n) lv = 2'd0;
            es[2*s +: 2] = lv;
        end
        ef = inh_n ? m_mode : '0;
        n_chk++;
        if (seg_lvl !== es || com_lvl !== ec || port_fn !== ef) begin
            n_err++;
            $display("FAIL %s at cycle %0d: seg=%h com=%h fn=%b expected seg=%h com=%h fn=%b",
                     tag, tick, seg_lvl, com_lvl, port_fn, es, ec, ef);
        end
    endtask

    task automatic sweep(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_outputs(tag);
        end
    endtask

    function automatic logic [PW-1:0] make_pay(input int seed, input logic [NP-1:0] mode,
                                               input logic [NP-1:0] val);
        logic [PW-1:0] p;
        for (int i = 0; i < DW; i++) p[i] = ((i * seed + seed / 3) % 7) < 3;
        p[DW +: NP]      = mode;
        p[DW + NP +: NP] = val;
        return p;
    endfunction

    // R5: address LSB first, then payload LSB first, sampled on rising shift clock
    task automatic send_frame(input logic [7:0] a, input logic [PW-1:0] pay, input int nbits);
        @(negedge clk);
        ser_ce = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 8 + nbits; i++) begin
            if (i < 8)            ser_di = a[i];
            else if (i - 8 < PW)  ser_di = pay[i - 8];
            else                  ser_di = 1'b0;
            repeat (2) @(negedge clk);
            ser_clk = 1'b1;
            repeat (3) @(negedge clk);
            ser_clk = 1'b0;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
        ser_ce = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic accept(input logic [PW-1:0] pay);
        m_disp = pay[DW-1:0];
        m_mode = pay[DW +: NP];
        m_val  = pay[DW + NP +: NP];
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [PW-1:0] pa, pb, pc, pd, pe;
        pa = make_pay(5,  4'b0000, 4'b0000);
        pb = make_pay(11, 4'b0000, 4'b1111);
        pc = make_pay(3,  4'b1010, 4'b1110);
        pd = make_pay(13, 4'b0110, 4'b0100);
        pe = make_pay(17, 4'b1111, 4'b0101);

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R1 reset state");

        sweep(2 * FRAME, "R2 R3 R4 blank scan");

        send_frame(ADDR, pa, PW);
        accept(pa);
        sweep(FRAME, "R5 R4 pattern A");

        send_frame(ADDR ^ 8'h01, pb, PW);
        sweep(64, "R6 foreign address ignored");
        send_frame(ADDR ^ 8'h80, pb, PW);
        sweep(64, "R6 foreign address msb ignored");

        send_frame(ADDR, pb, PW - 1);
        sweep(64, "R7 short frame discarded");
        send_frame(ADDR, pb, PW + 1);
        sweep(64, "R7 long frame discarded");

        ser_di = 1'b1;
        for (int i = 0; i < 20; i++) begin
            repeat (3) @(negedge clk);
            ser_clk = ~ser_clk;
        end
        ser_clk = 1'b0;
        ser_di  = 1'b0;
        sweep(64, "R11 clock with enable low");

        send_frame(ADDR, pb, PW);
        accept(pb);
        sweep(FRAME, "R5 R6 pattern B accepted");

        send_frame(ADDR, pc, PW);
        accept(pc);
        sweep(FRAME, "R8 ports high");

        send_frame(ADDR, pd, PW);
        accept(pd);
        sweep(FRAME, "R8 ports mixed");

        @(negedge clk);
        inh_n = 1'b0;
        sweep(PH, "R9 inhibit blank");
        send_frame(ADDR, pe, PW);
        accept(pe);
        sweep(64, "R9 R10 inhibit after load");
        inh_n = 1'b1;
        sweep(FRAME, "R10 load under inhibit shown");

        finish_run();
    end

endmodule